// File: doc/BRIEF.md
# Endpoint DMA Enable Control

This block holds one DMA-enable bit for each endpoint of a USB device controller. Software changes the bits through two write-only strobed ports. One port turns bits on and the other turns them off. A registered read port returns the enable word, the word of clear requests still waiting, a summary interrupt word and a single "proceed" flag. The DMA engine supplies a per-endpoint "transfer active" vector, a per-endpoint "transfer error" vector and a one-cycle pulse that raises the proceed flag.

The two lowest endpoints are the control pair, and their enable bits can never be set. A clear aimed at an endpoint that is still moving data does not take effect at once. It is parked in a pending bit and applied when the endpoint's active input goes low. An error report removes the enable at once. Any write to the clear port, whatever its data, drops the proceed flag. The summary word has one bit per incoming 32-bit interrupt status register. That bit is high when any bit of its register is high.

Top module: `ep_dma_ctrl`

## Requirements
- R1: A set-port write with a 1 in bit i (i >= 2) makes enable bit i equal to 1 at the next clock edge. A 0 in a bit leaves that enable bit unchanged.
- R2: Enable bits 0 and 1 (the control OUT and control IN endpoints) read as 0 whatever the set port receives.
- R3: A clear-port write with a 1 in bit i clears enable bit i at the next edge when `ep_busy[i]` is low. A 0 in a bit has no effect.
- R4: A `proceed_pulse` raises the proceed flag. Any clear-port write drops it, whatever the data. When both happen in the same cycle, the flag ends up 0.
- R5: A clear request for an enabled endpoint whose `ep_busy` bit is high leaves the enable bit at 1 and sets its pending bit. At the first edge where `ep_busy` is low, both the enable bit and the pending bit go to 0.
- R6: An `ep_err` bit clears both the enable bit and the pending bit of its endpoint at the next edge.
- R7: Summary bit k is the OR of the 32 bits `irq_src[32k+31:32k]`.
- R8: After reset, all enable bits, all pending bits and the proceed flag are 0.
- R9: A set write to an endpoint that has a pending clear cancels that clear. The enable bit stays 1 after the transfer ends.
- R10: Per endpoint, an error beats a clear, and a clear beats a set that arrives in the same cycle.
- R11: `rd_data` is registered and shows, one edge after `rd_addr` is applied, the selected word. Select 0 gives the enable word, 1 the pending word, 2 the summary word in the low bits with upper bits 0, and 3 the proceed flag in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Strobe for the set port |
| set_data | input | 32 | Bits of endpoints to enable |
| clr_we | input | 1 | Strobe for the clear port |
| clr_data | input | 32 | Bits of endpoints to disable |
| ep_busy | input | 32 | Transfer active per endpoint |
| ep_err | input | 32 | Transfer error per endpoint |
| proceed_pulse | input | 1 | One-cycle request to raise the proceed flag |
| irq_src | input | 128 | Four 32-bit interrupt status registers, concatenated |
| rd_addr | input | 2 | Read select |
| rd_data | output | 32 | Registered read data |

## Verification
A pending bit that is lost shows up as an enable bit that falls while its endpoint is still busy. A pending bit that is never released shows up as an enable bit that stays at 1 after busy falls. Either fault is visible on the enable word two edges after the triggering cycle: one edge to update the state and one edge for the read register. A wrong priority between error, clear and set shows in the same window. A stuck proceed flag is visible on select 3 one edge after it is read.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

   typedef enum logic [1:0] {
      SEL_ENABLE  = 2'd0,
      SEL_PENDING = 2'd1,
      SEL_SUMMARY = 2'd2,
      SEL_PROCEED = 2'd3
   } rd_sel_e;

   localparam int unsigned SRC_WORD_W = 32;

endpackage

// File: rtl/ep_dma_slice.sv
module ep_dma_slice #(
   parameter bit LOCKED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_hit,
   input  logic clr_hit,
   input  logic busy,
   input  logic err,
   output logic en,
   output logic pend
);

   localparam logic OPEN = ~LOCKED;

   logic set_ok;
   logic en_q;
   logic pend_q;

   assign set_ok = set_hit & OPEN;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (err) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (clr_hit) begin
         if (busy) begin
            pend_q <= en_q;
         end else begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
         end
      end else if (set_ok) begin
         en_q   <= 1'b1;
         pend_q <= 1'b0;
      end else if (pend_q && !busy) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end
   end

   assign en   = en_q;
   assign pend = pend_q;

   // R6
   err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (!en_q && !pend_q));
   // R5
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && busy && en_q && !err) |=> (en_q && pend_q));
   // R3
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !busy && !err) |=> !en_q);
   // R10
   clr_over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && set_hit && !busy) |=> !en_q);
   // R9
   pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> en_q);
   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !busy && !err && !clr_hit && !set_hit) |=> !en_q);

endmodule

// File: rtl/ep_dma_proceed.sv
module ep_dma_proceed (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic drop,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (drop)   flag_q <= 1'b0;
      else if (raise)  flag_q <= 1'b1;
   end

   assign flag = flag_q;

   // R4
   proceed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !flag_q);
   // R4
   proceed_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raise && !drop) |=> flag_q);

endmodule

// File: rtl/ep_dma_irq_sum.sv
module ep_dma_irq_sum #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned SRC_W   = 32
) (
   input  logic [NUM_SRC*SRC_W-1:0] src,
   output logic [NUM_SRC-1:0]       summary
);

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_or
      assign summary[k] = |src[k*SRC_W +: SRC_W];
   end

endmodule

// File: rtl/ep_dma_rd_port.sv
module ep_dma_rd_port #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic [DW-1:0] w_enable,
   input  logic [DW-1:0] w_pending,
   input  logic [DW-1:0] w_summary,
   input  logic [DW-1:0] w_proceed,
   output logic [DW-1:0] data
);

   import ep_dma_pkg::*;

   rd_sel_e       sel_e;
   logic [DW-1:0] mux_d;
   logic [DW-1:0] data_q;

   assign sel_e = rd_sel_e'(sel);

   always_comb begin
      unique case (sel_e)
         SEL_ENABLE:  mux_d = w_enable;
         SEL_PENDING: mux_d = w_pending;
         SEL_SUMMARY: mux_d = w_summary;
         SEL_PROCEED: mux_d = w_proceed;
         default:     mux_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= mux_d;
   end

   assign data = data_q;

   // R11
   rd_enable_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd0) |=> (data_q == $past(w_enable)));
   // R11
   rd_proceed_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd3) |=> (data_q == $past(w_proceed)));

endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl #(
   parameter int unsigned NUM_EP   = 32,
   parameter int unsigned NUM_CTRL = 2,
   parameter int unsigned NUM_SRC  = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      set_we,
   input  logic [NUM_EP-1:0]                         set_data,
   input  logic                                      clr_we,
   input  logic [NUM_EP-1:0]                         clr_data,
   input  logic [NUM_EP-1:0]                         ep_busy,
   input  logic [NUM_EP-1:0]                         ep_err,
   input  logic                                      proceed_pulse,
   input  logic [NUM_SRC*ep_dma_pkg::SRC_WORD_W-1:0] irq_src,
   input  logic [1:0]                                rd_addr,
   output logic [NUM_EP-1:0]                         rd_data
);

   localparam int unsigned SRC_W = ep_dma_pkg::SRC_WORD_W;
   localparam int unsigned PAD_W = NUM_EP - NUM_SRC;

   if (NUM_EP < 2 || NUM_EP > 32) begin : g_bad_ep
      $error("NUM_EP must lie in 2..32");
   end
   if (NUM_CTRL >= NUM_EP) begin : g_bad_ctrl
      $error("NUM_CTRL must be below NUM_EP");
   end
   if (NUM_SRC < 1 || NUM_SRC > NUM_EP) begin : g_bad_src
      $error("NUM_SRC must lie in 1..NUM_EP");
   end

   logic [NUM_EP-1:0]  en_vec;
   logic [NUM_EP-1:0]  pend_vec;
   logic [NUM_SRC-1:0] sum_vec;
   logic [NUM_EP-1:0]  sum_wide;
   logic [NUM_EP-1:0]  proc_wide;
   logic               proc_flag;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      ep_dma_slice #(
         .LOCKED (i < NUM_CTRL)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_hit (set_we & set_data[i]),
         .clr_hit (clr_we & clr_data[i]),
         .busy    (ep_busy[i]),
         .err     (ep_err[i]),
         .en      (en_vec[i]),
         .pend    (pend_vec[i])
      );
   end

   ep_dma_proceed u_proceed (
      .clk   (clk),
      .rst_n (rst_n),
      .raise (proceed_pulse),
      .drop  (clr_we),
      .flag  (proc_flag)
   );

   ep_dma_irq_sum #(
      .NUM_SRC (NUM_SRC),
      .SRC_W   (SRC_W)
   ) u_sum (
      .src     (irq_src),
      .summary (sum_vec)
   );

   if (PAD_W == 0) begin : g_sum_full
      assign sum_wide = sum_vec;
   end else begin : g_sum_pad
      assign sum_wide = {{PAD_W{1'b0}}, sum_vec};
   end

   assign proc_wide = {{(NUM_EP-1){1'b0}}, proc_flag};

   ep_dma_rd_port #(
      .DW (NUM_EP)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (rd_addr),
      .w_enable  (en_vec),
      .w_pending (pend_vec),
      .w_summary (sum_wide),
      .w_proceed (proc_wide),
      .data      (rd_data)
   );

   // R2
   ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (en_vec[NUM_CTRL-1:0] == '0));
   // R7
   summary_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_src) == (|sum_vec));

endmodule

// File: tb/tb_ep_dma_ctrl.sv
module tb_ep_dma_ctrl;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         set_we = 1'b0;
   logic [31:0]  set_data = '0;
   logic         clr_we = 1'b0;
   logic [31:0]  clr_data = '0;
   logic [31:0]  ep_busy = '0;
   logic [31:0]  ep_err = '0;
   logic         proceed_pulse = 1'b0;
   logic [127:0] irq_src = '0;
   logic [1:0]   rd_addr = 2'd0;
   logic [31:0]  rd_data;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   ep_dma_ctrl dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_we        (set_we),
      .set_data      (set_data),
      .clr_we        (clr_we),
      .clr_data      (clr_data),
      .ep_busy       (ep_busy),
      .ep_err        (ep_err),
      .proceed_pulse (proceed_pulse),
      .irq_src       (irq_src),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle of drive, starting and ending at a falling edge
   task automatic drive(input logic sw, input logic [31:0] sd, input logic cw,
                        input logic [31:0] cd, input logic [31:0] ed, input logic pp);
      set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
      ep_err = ed; proceed_pulse = pp;
      @(negedge clk);
      set_we = 1'b0; set_data = '0; clr_we = 1'b0; clr_data = '0;
      ep_err = '0; proceed_pulse = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(2'd0, d); check("R8 enable", d, 32'h0);
      rd(2'd1, d); check("R8 pending", d, 32'h0);
      rd(2'd3, d); check("R8 proceed", d, 32'h0);
   endtask

   task automatic t_set;
      logic [31:0] d;
      drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
      rd(2'd0, d); check("R1 R2 set all", d, 32'hFFFF_FFFC);
      drive(1, 32'h0, 0, 0, 0, 0);
      rd(2'd0, d); check("R1 zero write", d, 32'hFFFF_FFFC);
   endtask

   task automatic t_clear_idle;
      logic [31:0] d;
      drive(0, 0, 1, 32'h0000_00F0, 0, 0);
      rd(2'd0, d); check("R3 idle clear", d, 32'hFFFF_FF0C);
      drive(0, 0, 1, 32'h0, 0, 0);
      rd(2'd0, d); check("R3 zero clear", d, 32'hFFFF_FF0C);
   endtask

   task automatic t_clear_busy;
      logic [31:0] d;
      ep_busy[8] = 1'b1;
      drive(0, 0, 1, 32'h0000_0100, 0, 0);
      rd(2'd0, d); check("R5 held while busy", d, 32'hFFFF_FF0C);
      rd(2'd1, d); check("R5 pending set", d, 32'h0000_0100);
      ep_busy[8] = 1'b0;
      @(negedge clk);
      rd(2'd0, d); check("R5 released", d, 32'hFFFF_FE0C);
      rd(2'd1, d); check("R5 pending gone", d, 32'h0);
   endtask

   task automatic t_cancel;
      logic [31:0] d;
      ep_busy[9] = 1'b1;
      drive(0, 0, 1, 32'h0000_0200, 0, 0);
      rd(2'd1, d); check("R9 pending before set", d, 32'h0000_0200);
      drive(1, 32'h0000_0200, 0, 0, 0, 0);
      rd(2'd1, d); check("R9 pending cancelled", d, 32'h0);
      ep_busy[9] = 1'b0;
      @(negedge clk);
      rd(2'd0, d); check("R9 enable kept", d, 32'hFFFF_FE0C);
   endtask

   task automatic t_error;
      logic [31:0] d;
      drive(0, 0, 0, 0, 32'h0000_0400, 0);
      rd(2'd0, d); check("R6 error clear", d, 32'hFFFF_FA0C);
      drive(1, 32'h0000_0400, 0, 0, 32'h0000_0400, 0);
      rd(2'd0, d); check("R10 error beats set", d, 32'hFFFF_FA0C);
      drive(1, 32'h0000_0800, 1, 32'h0000_0800, 0, 0);
      rd(2'd0, d); check("R10 clear beats set", d, 32'hFFFF_F20C);
      ep_busy[12] = 1'b1;
      drive(0, 0, 1, 32'h0000_1000, 0, 0);
      drive(0, 0, 0, 0, 32'h0000_1000, 0);
      rd(2'd1, d); check("R6 error drops pending", d, 32'h0);
      rd(2'd0, d); check("R6 error on busy", d, 32'hFFFF_E20C);
      ep_busy[12] = 1'b0;
   endtask

   task automatic t_proceed;
      logic [31:0] d;
      drive(0, 0, 0, 0, 0, 1);
      rd(2'd3, d); check("R4 raised", d, 32'h1);
      drive(0, 0, 1, 32'h0, 0, 0);
      rd(2'd3, d); check("R4 dropped by empty clear", d, 32'h0);
      rd(2'd0, d); check("R3 empty clear keeps enables", d, 32'hFFFF_E20C);
      drive(0, 0, 1, 32'h0, 0, 1);
      rd(2'd3, d); check("R4 drop beats raise", d, 32'h0);
      drive(0, 0, 0, 0, 0, 1);
      rd(2'd0, d);
      rd_addr = 2'd3;
      #1;
      check("R11 no change before edge", rd_data, 32'hFFFF_E20C);
      @(negedge clk);
      check("R11 one edge later", rd_data, 32'h1);
   endtask

   task automatic t_summary;
      logic [31:0] d;
      irq_src = '0;
      rd(2'd2, d); check("R7 all quiet", d, 32'h0);
      irq_src[5] = 1'b1;
      irq_src[64+31] = 1'b1;
      rd(2'd2, d); check("R7 regs 0 and 2", d, 32'h5);
      irq_src = '0;
      irq_src[96] = 1'b1;
      rd(2'd2, d); check("R7 reg 3", d, 32'h8);
      irq_src = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_clear_idle();
      t_clear_busy();
      t_cancel();
      t_error();
      t_proceed();
      t_summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule